// File: doc/BRIEF.md
# ATA Task-File Status and Device-Control Registers

This block is the host-facing status and device-control pair of an ATA-style storage device. The host reads an 8-bit status byte built from the device core's live flags. It can read that byte at two addresses. A read at the primary status address acknowledges a pending interrupt. A read at the alternate address only observes the byte and acknowledges nothing.

A host write to the device-control register does two things. It gates the interrupt request through an active-low mask bit, and it holds the core in soft reset for as long as its reset bit stays 1. The core signals an interrupt event with a one-cycle pulse. The block keeps that event pending until the host acknowledges it or a soft reset discards it. The enable bit only masks the pending event on the output; it never erases it.

Top module: `ata_tf_status`

## Requirements
- R1: With BUSY clear, a status read returns the core flags at fixed bit positions: bit 7 BUSY, bit 6 ready, bit 5 write fault, bit 4 seek complete, bit 3 data request, bit 2 corrected error, bit 1 zero, bit 0 error. Read data is registered and valid in the cycle after the read strobe.
- R2: While the core reports busy, every status read returns 8'h80, so no stale flag reaches the host.
- R3: Bit 1 of the status byte always reads 0.
- R4: A read at the primary status address (3'd7) clears the pending interrupt, and the interrupt output falls in the cycle after the strobe.
- R5: A read at the alternate status address (3'd6) returns the same byte as the primary address and leaves the pending interrupt unchanged.
- R6: The interrupt output is high only while an event is pending and the mask bit (control bit 1) is 0. A masked pending event is kept, and it shows on the output once the mask is cleared.
- R7: A write to the control address (3'd6) with bit 2 = 1 raises the soft-reset output in the next cycle. The output stays high until a control write with bit 2 = 0.
- R8: A soft reset discards the pending interrupt, ignores events while it lasts, makes status reads return 8'h80 (busy forced, ready 0), and forces the mask to 1. The write that ends the soft reset also leaves the mask at 1, so a further write is needed to unmask.
- R9: After power-on reset, soft reset is 0, the mask is 1, nothing is pending and the read data is 8'h00.
- R10: Control bits 7..3 and bit 0 have no effect on the write.
- R11: With the default priority, an interrupt event in the same cycle as a primary status read stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| host_addr | input | 3 | Host register select |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| core_busy | input | 1 | Core owns the registers |
| core_ready | input | 1 | Core can accept a command |
| core_wfault | input | 1 | Write fault seen |
| core_seekdone | input | 1 | Seek complete |
| core_drq | input | 1 | Data transfer requested |
| core_corr | input | 1 | Corrected data error |
| core_err | input | 1 | Last command ended in error |
| core_irq | input | 1 | One-cycle interrupt event |
| intrq | output | 1 | Host interrupt request |
| soft_rst | output | 1 | Soft reset to the core |

## Verification
The assertions assume that the host strobes last a single cycle and that read and write never arrive together. They also assume that core_irq is a one-cycle pulse. The bench drives every strobe as a one-cycle pulse between falling edges and never raises host_rd and host_wr in the same cycle. It holds the core flags steady across each read, so every sampled byte reflects a single, settled input pattern.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
   localparam int TF_DATA_W = 8;
   localparam int ST_BUSY   = 7;
   localparam int ST_READY  = 6;
   localparam int ST_WFAULT = 5;
   localparam int ST_SEEK   = 4;
   localparam int ST_DRQ    = 3;
   localparam int ST_CORR   = 2;
   localparam int ST_INDEX  = 1;
   localparam int ST_ERROR  = 0;
   localparam int CT_SRST   = 2;
   localparam int CT_MASK   = 1;

   typedef struct packed {
      logic busy;
      logic ready;
      logic wfault;
      logic seekdone;
      logic drq;
      logic corr;
      logic err;
   } core_flags_t;
endpackage

// File: rtl/ata_tf_devctl.sv
module ata_tf_devctl
   import ata_tf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic              srst_q,
   output logic              mask_q
);
   generate
      if (DATA_W != TF_DATA_W) begin : g_bad_width
         $error("ata_tf_devctl: DATA_W must equal 8");
      end
   endgenerate

   logic unused_wbits;
   assign unused_wbits = ^{wdata[DATA_W-1:CT_SRST+1], wdata[0]};

   logic next_srst;
   logic next_mask;

   always_comb begin
      next_srst = srst_q;
      next_mask = mask_q;
      if (wr_en) begin
         next_srst = wdata[CT_SRST];
         if (wdata[CT_SRST] || srst_q) begin
            next_mask = 1'b1;
         end else begin
            next_mask = wdata[CT_MASK];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b0;
         mask_q <= 1'b1;
      end else begin
         srst_q <= next_srst;
         mask_q <= next_mask;
      end
   end

   // R7
   srst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[CT_SRST]) |=> (srst_q && mask_q));

   // R8
   srst_exit_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(srst_q) |-> mask_q);

   // R7
   srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_q && !wr_en) |=> srst_q);
endmodule

// File: rtl/ata_tf_irq_pend.sv
module ata_tf_irq_pend #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic ack,
   input  logic flush,
   input  logic mask,
   output logic pend_q,
   output logic irq_out
);
   logic pend_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            pend_d = pend_q;
            if (evt) begin
               pend_d = 1'b1;
            end else if (ack) begin
               pend_d = 1'b0;
            end
         end
      end else begin : g_ack_first
         always_comb begin
            pend_d = pend_q;
            if (ack) begin
               pend_d = 1'b0;
            end else if (evt) begin
               pend_d = 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (flush) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
      end
   end

   assign irq_out = pend_q & ~mask;

   // R4
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !evt) |=> !pend_q);

   // R6
   masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ack && !flush) |=> pend_q);

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !pend_q);
endmodule

// File: rtl/ata_tf_status_view.sv
module ata_tf_status_view
   import ata_tf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              rd_hit,
   input  logic              force_busy,
   input  core_flags_t       flags,
   output logic [DATA_W-1:0] rdata_q
);
   generate
      if (DATA_W != TF_DATA_W) begin : g_bad_width
         $error("ata_tf_status_view: DATA_W must equal 8");
      end
   endgenerate

   logic              busy_eff;
   logic [DATA_W-1:0] live_byte;

   assign busy_eff = flags.busy | force_busy;

   always_comb begin
      live_byte = '0;
      if (busy_eff) begin
         live_byte[ST_BUSY] = 1'b1;
      end else begin
         live_byte[ST_READY]  = flags.ready;
         live_byte[ST_WFAULT] = flags.wfault;
         live_byte[ST_SEEK]   = flags.seekdone;
         live_byte[ST_DRQ]    = flags.drq;
         live_byte[ST_CORR]   = flags.corr;
         live_byte[ST_INDEX]  = 1'b0;
         live_byte[ST_ERROR]  = flags.err;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         rdata_q <= rd_hit ? live_byte : '0;
      end
   end

   // R2
   busy_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_hit && busy_eff) |=> (rdata_q == 8'h80));

   // R3
   index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_q[ST_INDEX]);

   // R1
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/ata_tf_status.sv
module ata_tf_status
   import ata_tf_pkg::*;
#(
   parameter int         ADDR_W      = 3,
   parameter int         DATA_W      = 8,
   parameter logic [2:0] STATUS_ADDR = 3'd7,
   parameter logic [2:0] ALTCTL_ADDR = 3'd6,
   parameter bit         SET_WINS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              core_busy,
   input  logic              core_ready,
   input  logic              core_wfault,
   input  logic              core_seekdone,
   input  logic              core_drq,
   input  logic              core_corr,
   input  logic              core_err,
   input  logic              core_irq,
   output logic              intrq,
   output logic              soft_rst
);
   generate
      if (ADDR_W != 3) begin : g_bad_addr
         $error("ata_tf_status: ADDR_W must be 3");
      end
      if (STATUS_ADDR == ALTCTL_ADDR) begin : g_addr_clash
         $error("ata_tf_status: status and alternate addresses must differ");
      end
   endgenerate

   logic        sel_status;
   logic        sel_altctl;
   logic        srst_q;
   logic        mask_q;
   logic        pend_q;
   core_flags_t flags;

   assign sel_status = (host_addr == STATUS_ADDR);
   assign sel_altctl = (host_addr == ALTCTL_ADDR);

   assign flags = '{busy: core_busy, ready: core_ready, wfault: core_wfault,
                    seekdone: core_seekdone, drq: core_drq, corr: core_corr,
                    err: core_err};

   ata_tf_devctl #(.DATA_W(DATA_W)) u_devctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (host_wr && sel_altctl),
      .wdata  (host_wdata),
      .srst_q (srst_q),
      .mask_q (mask_q)
   );

   ata_tf_irq_pend #(.SET_WINS(SET_WINS)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (core_irq),
      .ack     (host_rd && sel_status),
      .flush   (srst_q),
      .mask    (mask_q),
      .pend_q  (pend_q),
      .irq_out (intrq)
   );

   ata_tf_status_view #(.DATA_W(DATA_W)) u_view (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (host_rd),
      .rd_hit     (sel_status || sel_altctl),
      .force_busy (srst_q),
      .flags      (flags),
      .rdata_q    (host_rdata)
   );

   assign soft_rst = srst_q;

   // R8
   srst_quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !intrq);

   // R5
   alt_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && sel_altctl && !core_irq && !srst_q) |=> (pend_q == $past(pend_q)));

   // R11
   set_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SET_WINS && core_irq && host_rd && sel_status && !srst_q) |=> pend_q);
endmodule

// File: tb/ata_tf_status_bench.sv
module ata_tf_status_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_addr = '0;
   logic       host_rd = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic [6:0] core = '0;
   logic       core_irq = 1'b0;
   logic       intrq;
   logic       soft_rst;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   localparam logic [2:0] A_ST  = 3'd7;
   localparam logic [2:0] A_ALT = 3'd6;

   always #2 clk = ~clk;

   ata_tf_status u_ata_tf_status (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .core_busy(core[6]), .core_ready(core[5]), .core_wfault(core[4]),
      .core_seekdone(core[3]), .core_drq(core[2]), .core_corr(core[1]),
      .core_err(core[0]), .core_irq(core_irq),
      .intrq(intrq), .soft_rst(soft_rst)
   );

   // core bits {busy,ready,wfault,seek,drq,corr,err}, expected byte
   localparam logic [14:0] VEC [8] = '{
      {7'b0000000, 8'h00}, {7'b0100000, 8'h40},
      {7'b0111111, 8'h7D}, {7'b1111111, 8'h80},
      {7'b0001010, 8'h14}, {7'b0100001, 8'h41},
      {7'b1000000, 8'h80}, {7'b0101100, 8'h58}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a);
      @(negedge clk); host_addr = a; host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); host_addr = A_ALT; host_wdata = d; host_wr = 1'b1;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic irq_pulse();
      @(negedge clk); core_irq = 1'b1;
      @(negedge clk); core_irq = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 rdata", host_rdata, 8'h00);
      chk("R9 intrq", {7'b0, intrq}, 8'h00);
      chk("R9 soft_rst", {7'b0, soft_rst}, 8'h00);
      rst_n = 1'b1;

      // R1 R2 R3 R5: table walk, odd entries through the alternate address
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); core = VEC[i][14:8];
         rd((i % 2) ? A_ALT : A_ST);
         chk((i % 2) ? "R5 alt byte" : "R1 status byte", host_rdata, VEC[i][7:0]);
         chk("R3 index bit", {7'b0, host_rdata[1]}, 8'h00);
      end
      @(negedge clk); core = 7'b0100000;

      // R9 mask set after reset, R6 pending kept while masked
      irq_pulse();
      chk("R6 masked", {7'b0, intrq}, 8'h00);
      wr(8'h00);
      chk("R6 unmask shows pending", {7'b0, intrq}, 8'h01);
      // R5 alternate read keeps it
      rd(A_ALT);
      chk("R5 alt keeps irq", {7'b0, intrq}, 8'h01);
      // R4 primary read clears it
      rd(A_ST);
      chk("R4 status read clears", {7'b0, intrq}, 8'h00);
      chk("R4 status byte", host_rdata, 8'h40);

      // R11 event and acknowledge in the same cycle
      @(negedge clk); host_addr = A_ST; host_rd = 1'b1; core_irq = 1'b1;
      @(negedge clk); host_rd = 1'b0; core_irq = 1'b0;
      chk("R11 set wins", {7'b0, intrq}, 8'h01);
      rd(A_ST);
      chk("R4 cleared again", {7'b0, intrq}, 8'h00);

      // R10 ignored bits: reset bit clear, mask clear
      wr(8'hF9);
      chk("R10 no soft reset", {7'b0, soft_rst}, 8'h00);
      irq_pulse();
      chk("R10 still unmasked", {7'b0, intrq}, 8'h01);
      wr(8'hFB);
      chk("R6 masked by bit1", {7'b0, intrq}, 8'h00);
      wr(8'h00);
      chk("R6 back unmasked", {7'b0, intrq}, 8'h01);

      // R7 R8 soft reset
      wr(8'h04);
      chk("R7 soft_rst set", {7'b0, soft_rst}, 8'h01);
      chk("R8 pending dropped", {7'b0, intrq}, 8'h00);
      @(negedge clk); core = 7'b0111111;
      rd(A_ST);
      chk("R8 status busy", host_rdata, 8'h80);
      irq_pulse();
      repeat (4) @(negedge clk);
      chk("R7 soft_rst held", {7'b0, soft_rst}, 8'h01);
      wr(8'h00);
      chk("R7 soft_rst released", {7'b0, soft_rst}, 8'h00);
      chk("R8 event ignored", {7'b0, intrq}, 8'h00);
      irq_pulse();
      chk("R8 mask still set", {7'b0, intrq}, 8'h00);
      wr(8'h00);
      chk("R8 unmask after reset", {7'b0, intrq}, 8'h01);
      rd(A_ST);
      chk("R1 status after reset", host_rdata, 8'h7D);

      finish_run();
   end
endmodule